// File: doc/BRIEF.md
# GPIO Bank Output and Direction Register File

This block keeps the output levels, the direction bits and the output-enable bits for a single bank of up to 32 general-purpose pins. Software reaches it over a plain 32-bit register bus: an address, a write strobe, write data and combinational read data, with every access completing in one cycle and no handshake. The block drives a per-pin output value vector and a per-pin output-enable vector toward the pads, and it samples a per-pin input vector through a two-stage synchroniser.

Output levels are changed through two write-only masked-write ports, one for the lower sixteen pins and one for the upper sixteen. Each write carries a sixteen-bit inhibit mask in its upper half-word and sixteen new levels in its lower half-word, so any subset of pins in a half can be set or cleared in a single bus write with no read-modify-write. A read-only register shows the synchronised pin levels. The register offsets depend on the bank index parameter, so several instances can share one address space.

Top module: `gpio_bank_regs`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears the direction, output-enable and output level registers, so pin_out and pin_oe are all zeros and both writable registers read 0.
- R2: A write to the lower masked port (offset 8*BANK) updates pin i, for i from 0 to 15, to wdata bit i when wdata bit 16+i is 0, and leaves pin i unchanged when that mask bit is 1.
- R3: A write to the upper masked port (offset 8*BANK+4) updates pin 16+j, for j from 0 to 15, to wdata bit j when wdata bit 16+j is 0, and leaves it unchanged when that mask bit is 1.
- R4: A write to one masked port never changes any pin of the other half.
- R5: The direction register at offset 0x204+0x40*BANK is read/write, bit i for pin i, 1 meaning output.
- R6: The output-enable register at offset 0x208+0x40*BANK is read/write, bit i for pin i.
- R7: pin_oe bit i is 1 exactly when direction bit i and output-enable bit i are both 1.
- R8: The read-only input register at offset 0x060+4*BANK returns pin_in after two rising clock edges: a change made before edge 1 still reads the old value after edge 1 and the new value after edge 2.
- R9: Reads of the two masked ports and of any unmapped offset return 0.
- R10: Writes to the input register or to an unmapped offset change no register and no output.
- R11: A write takes effect at the rising edge that samples bus_wr; read data follows the address in the same cycle, so a read during the write cycle still shows the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Output level per pin |
| pin_oe | output | NPINS | Output buffer enable per pin |

## Verification
Register writes land on pin_out, pin_oe and the read data one edge after the strobe is sampled, read data follows the address inside the same cycle, and a pin input change needs two edges before the input register shows it. The bench drives all inputs just after a rising edge and has its scoreboard compare at the following falling edge, so each expectation is queued only in the cycle where the result is due. The input-latency and write-cycle cases queue an expectation for the old value one edge early and for the new value at the due edge, which pins down both the lower and the upper bound.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

    localparam int unsigned GPB_DATA_W = 32;
    localparam int unsigned GPB_HALF_W = 16;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_OUT_LO,
        SEL_OUT_HI,
        SEL_PINS,
        SEL_DIR,
        SEL_OEN
    } gpb_sel_e;

    function automatic int unsigned gpb_off_lo(input int unsigned bank);
        return 8 * bank;
    endfunction

    function automatic int unsigned gpb_off_hi(input int unsigned bank);
        return 8 * bank + 4;
    endfunction

    function automatic int unsigned gpb_off_pins(input int unsigned bank);
        return 32'h060 + 4 * bank;
    endfunction

    function automatic int unsigned gpb_off_dir(input int unsigned bank);
        return 32'h204 + 32'h40 * bank;
    endfunction

    function automatic int unsigned gpb_off_oen(input int unsigned bank);
        return 32'h208 + 32'h40 * bank;
    endfunction

endpackage

// File: rtl/gpb_decode.sv
module gpb_decode
    import gpb_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned BANK   = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output gpb_sel_e          sel
);
    localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(gpb_off_lo(BANK));
    localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(gpb_off_hi(BANK));
    localparam logic [ADDR_W-1:0] A_PINS = ADDR_W'(gpb_off_pins(BANK));
    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(gpb_off_dir(BANK));
    localparam logic [ADDR_W-1:0] A_OEN  = ADDR_W'(gpb_off_oen(BANK));

    always_comb begin
        unique case (addr)
            A_LO:    sel = SEL_OUT_LO;
            A_HI:    sel = SEL_OUT_HI;
            A_PINS:  sel = SEL_PINS;
            A_DIR:   sel = SEL_DIR;
            A_OEN:   sel = SEL_OEN;
            default: sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/gpb_sync.sv
module gpb_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;
    logic [1:0]   warm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;

    // Counts edges since reset so the latency check never looks past reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            warm_q <= 2'd0;
        else if (warm_q != 2'd2)
            warm_q <= warm_q + 2'd1;
    end

    p_sync_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/gpb_outreg.sv
module gpb_outreg
    import gpb_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic [GPB_DATA_W-1:0] wdata,
    output logic [NPINS-1:0]      out_q
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        localparam int unsigned DB = i % GPB_HALF_W;
        localparam int unsigned MB = DB + GPB_HALF_W;
        localparam bit          UPPER = (i >= GPB_HALF_W);

        logic port_wr;
        logic take;
        logic lvl_q;

        assign port_wr = UPPER ? wr_hi : wr_lo;
        assign take    = port_wr && !wdata[MB];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                lvl_q <= 1'b0;
            else if (take)
                lvl_q <= wdata[DB];
        end

        assign out_q[i] = lvl_q;

        p_pin_update_r2_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ((UPPER ? wr_hi : wr_lo) && !wdata[MB]) |=> (out_q[i] == $past(wdata[DB])));

        p_pin_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !((UPPER ? wr_hi : wr_lo) && !wdata[MB]) |=> $stable(out_q[i]));
    end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpb_pkg::*;
#(
    parameter int unsigned NPINS  = 32,
    parameter int unsigned BANK   = 1,
    parameter int unsigned ADDR_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic [GPB_DATA_W-1:0] bus_wdata,
    output logic [GPB_DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]      pin_in,
    output logic [NPINS-1:0]      pin_out,
    output logic [NPINS-1:0]      pin_oe
);
    localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(gpb_off_lo(BANK));
    localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(gpb_off_hi(BANK));
    localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(gpb_off_dir(BANK));
    localparam logic [ADDR_W-1:0] A_OEN = ADDR_W'(gpb_off_oen(BANK));

    gpb_sel_e         sel;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] oen_q;
    logic [NPINS-1:0] pins_sync;

    gpb_decode #(.ADDR_W(ADDR_W), .BANK(BANK)) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    gpb_sync #(.W(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pins_sync)
    );

    gpb_outreg #(.NPINS(NPINS)) u_outreg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_lo (bus_wr && (sel == SEL_OUT_LO)),
        .wr_hi (bus_wr && (sel == SEL_OUT_HI)),
        .wdata (bus_wdata),
        .out_q (pin_out)
    );

    // Register process for direction and output-enable.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            oen_q <= '0;
        end else if (bus_wr) begin
            unique case (sel)
                SEL_DIR: dir_q <= bus_wdata[NPINS-1:0];
                SEL_OEN: oen_q <= bus_wdata[NPINS-1:0];
                default: ;
            endcase
        end
    end

    // Output process: read mux and pad enables.
    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_PINS: bus_rdata[NPINS-1:0] = pins_sync;
            SEL_DIR:  bus_rdata[NPINS-1:0] = dir_q;
            SEL_OEN:  bus_rdata[NPINS-1:0] = oen_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign pin_oe = dir_q & oen_q;

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dir_q == '0 && oen_q == '0 && pin_out == '0));

    p_dir_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_DIR) |=> (dir_q == $past(bus_wdata[NPINS-1:0])));

    p_oen_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_OEN) |=> (oen_q == $past(bus_wdata[NPINS-1:0])));

    p_wo_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_LO || bus_addr == A_HI) |-> (bus_rdata == '0));

    p_ignored_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (sel == SEL_NONE || sel == SEL_PINS)) |=>
            ($stable(dir_q) && $stable(oen_q) && $stable(pin_out)));
endmodule

// File: tb/gpio_bank_regs_bench.sv
module gpio_bank_regs_bench;
    localparam int unsigned NPINS  = 32;
    localparam int unsigned BANK   = 1;
    localparam int unsigned ADDR_W = 12;
    localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(8 * BANK);
    localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(8 * BANK + 4);
    localparam logic [ADDR_W-1:0] A_PINS = ADDR_W'(12'h060 + 4 * BANK);
    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(12'h204 + 12'h040 * BANK);
    localparam logic [ADDR_W-1:0] A_OEN  = ADDR_W'(12'h208 + 12'h040 * BANK);
    localparam logic [ADDR_W-1:0] A_GAP  = 12'h100;

    localparam int K_RD  = 0;
    localparam int K_OUT = 1;
    localparam int K_OE  = 2;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NPINS-1:0]  pin_in = '0;
    logic [NPINS-1:0]  pin_out;
    logic [NPINS-1:0]  pin_oe;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    item_t sb[$];

    logic [31:0] m_out = '0;
    logic [31:0] m_dir = '0;
    logic [31:0] m_oen = '0;

    always #10 clk = ~clk;

    gpio_bank_regs #(.NPINS(NPINS), .BANK(BANK), .ADDR_W(ADDR_W)) u_gpio_bank_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    // Monitor: compares queued expectations at the falling edge.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.kind)
                K_RD:    act = bus_rdata;
                K_OUT:   act = pin_out;
                default: act = pin_oe;
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s kind=%0d actual=%08h expected=%08h", it.tag, it.kind, act, it.exp);
            end
        end
    end

    task automatic push(input int kind, input logic [31:0] exp, input string tag);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.tag  = tag;
        sb.push_back(it);
    endtask

    task automatic model_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        if (a == A_LO) begin
            for (int b = 0; b < 16; b++) if (!d[16 + b]) m_out[b] = d[b];
        end else if (a == A_HI) begin
            for (int b = 0; b < 16; b++) if (!d[16 + b]) m_out[16 + b] = d[b];
        end else if (a == A_DIR) begin
            m_dir = d;
        end else if (a == A_OEN) begin
            m_oen = d;
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic chk_rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        bus_addr = a;
        push(K_RD, exp, tag);
        @(negedge clk);
    endtask

    task automatic chk_pads(input string tag);
        @(posedge clk); #1;
        push(K_OUT, m_out, tag);
        push(K_OE, m_dir & m_oen, tag);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        chk_rd(A_DIR, 32'h0, "R1");
        chk_rd(A_OEN, 32'h0, "R1");
        chk_pads("R1");

        // R2: lower port, all mask bits clear, then a partial mask
        wr(A_LO, 32'h0000_A5A5);
        chk_pads("R2");
        wr(A_LO, 32'hFF00_1234);
        push(K_OUT, 32'h0000_A534, "R2");
        chk_pads("R2");

        // R3, R4: upper port does not touch the lower half
        wr(A_HI, 32'h0000_C3C3);
        chk_pads("R4");
        push(K_OUT, 32'hC3C3_A534, "R3");
        wr(A_HI, 32'hFFFF_0000);
        chk_pads("R3");
        wr(A_HI, 32'hFFEF_0010);
        push(K_OUT, 32'hC3D3_A534, "R3");
        chk_pads("R3");
        wr(A_LO, 32'hFFFE_0000);
        push(K_OUT, 32'hC3D3_A534, "R4");
        chk_pads("R4");

        // R5, R6, R7: direction and output-enable
        wr(A_DIR, 32'hF0F0_0F0F);
        chk_rd(A_DIR, 32'hF0F0_0F0F, "R5");
        wr(A_OEN, 32'hFF00_FF00);
        chk_rd(A_OEN, 32'hFF00_FF00, "R6");
        @(posedge clk); #1;
        push(K_OE, 32'hF000_0F00, "R7");
        @(negedge clk);

        // R9: write-only ports and unmapped space read as zero
        chk_rd(A_LO, 32'h0, "R9");
        chk_rd(A_HI, 32'h0, "R9");
        chk_rd(A_GAP, 32'h0, "R9");

        // R10: ignored writes
        wr(A_PINS, 32'hFFFF_FFFF);
        wr(A_GAP, 32'hFFFF_FFFF);
        wr(A_GAP, 32'h0000_0000);
        chk_pads("R10");
        chk_rd(A_DIR, 32'hF0F0_0F0F, "R10");
        chk_rd(A_OEN, 32'hFF00_FF00, "R10");
        chk_rd(A_PINS, 32'h0, "R10");

        // R8: two-edge input latency
        @(posedge clk); #1;
        pin_in = 32'hDEAD_BEEF;
        bus_addr = A_PINS;
        @(posedge clk); #1;
        push(K_RD, 32'h0, "R8");
        @(negedge clk);
        @(posedge clk); #1;
        push(K_RD, 32'hDEAD_BEEF, "R8");
        @(negedge clk);

        // R11: read in the write cycle shows the old value
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = A_DIR; bus_wdata = 32'h1234_5678;
        push(K_RD, 32'hF0F0_0F0F, "R11");
        @(negedge clk);
        @(posedge clk); #1;
        bus_wr = 1'b0;
        model_write(A_DIR, 32'h1234_5678);
        push(K_RD, 32'h1234_5678, "R11");
        @(negedge clk);

        // R1: reset in the middle of operation
        @(posedge clk); #1;
        rst_n = 1'b0;
        m_out = '0; m_dir = '0; m_oen = '0;
        bus_addr = A_OEN;
        push(K_RD, 32'h0, "R1");
        push(K_OUT, 32'h0, "R1");
        push(K_OE, 32'h0, "R1");
        @(negedge clk);
        @(posedge clk); #1;
        rst_n = 1'b1;
        chk_rd(A_DIR, 32'h0, "R1");

        repeat (2) @(posedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule